// File: doc/BRIEF.md
# Interrupt Priority Threshold Selector

This block decides, for a single target context of an interrupt controller, which interrupt source should be offered to that context. It looks at three per-source state vectors held as 32-bit words (pending, in-service and enabled-for-this-context), a small priority value for each source, and the context's threshold. It reports the identity of the winning source together with an interrupt-request level for the context.

The choice is the same as a scan from the lowest source number to the highest. The scan keeps a running best that starts at the threshold and replaces it only on a strictly greater priority. The hardware builds that scan as a balanced comparison tree. The result is captured in an output register, so the answer for a set of inputs appears one clock after they are sampled. Source number 0 is reserved to mean "nothing to take" and is never selected.

Top module: `irq_pick_top`

## Requirements
- R1: A source can be selected only when its pending bit is 1, its in-service bit is 0 and its enable bit is 1.
- R2: The selected source's priority is strictly greater than the threshold, so a priority equal to the threshold, or a priority of 0, never wins.
- R3: Among the sources that satisfy R1 and R2, the one with the highest priority is selected; on equal priority the lowest source number wins, including between sources in different 32-bit words.
- R4: When no source satisfies R1 and R2, `win_id` is 0.
- R5: `irq_req` is 1 exactly when `win_id` is nonzero.
- R6: Source n is found at bit n of each flat state vector (word n/32, bit n%32). Bits at positions NUM_SRC and above are ignored, and `win_id` is always below NUM_SRC.
- R7: Source 0 is never selected, whatever its pending, in-service, enable and priority values.
- R8: `win_id` and `irq_req` reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R9: While `rst_n` is low, `win_id` is 0 and `irq_req` is 0, and both clear as soon as reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_words | input | NWORD*32 | Pending bits, source n at bit n |
| claim_words | input | NWORD*32 | In-service bits, source n at bit n |
| en_words | input | NWORD*32 | Enable bits for this context, source n at bit n |
| prio_flat | input | NUM_SRC*PRIO_W | Source priorities, source n at bits [n*PRIO_W +: PRIO_W] |
| thresh | input | PRIO_W | Context threshold |
| win_id | output | ID_W | Selected source number, 0 when none |
| irq_req | output | 1 | Interrupt request level for the context |

## Verification
The assertions compare each registered result with a copy of the inputs that the checker captured at the same edge. They therefore assume that the inputs stay steady around the rising edge and carry no unknown values once reset is released. The bench changes every input only on the falling edge and drives all bits to known values before reset ends, including the padding bits above the last source. It reads the outputs on the following falling edge, so every comparison sees one complete sampled input set.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

    localparam int WORD_BITS = 32;

    // Number of 32-bit words needed to hold one bit per source
    function automatic int word_count(input int nsrc);
        return (nsrc + WORD_BITS - 1) / WORD_BITS;
    endfunction

    // Bits needed to name any source number 0 .. nsrc-1
    function automatic int id_width(input int nsrc);
        return (nsrc <= 2) ? 1 : $clog2(nsrc);
    endfunction

    // Leaf count of the comparison tree: next power of two
    function automatic int leaf_count(input int nsrc);
        return (nsrc <= 1) ? 1 : (1 << $clog2(nsrc));
    endfunction

endpackage

// File: rtl/irq_pick_elig.sv
module irq_pick_elig #(
    parameter int NUM_SRC = 40,
    parameter int NWORD   = irq_pick_pkg::word_count(NUM_SRC)
) (
    input  logic [NWORD*32-1:0] pend_words,
    input  logic [NWORD*32-1:0] claim_words,
    input  logic [NWORD*32-1:0] en_words,
    output logic [NUM_SRC-1:0]  elig
);

    localparam int FLAT_W = NWORD * 32;

    // Per word, per bit: source n lives at word n/32, bit n%32 (R6)
    for (genvar w = 0; w < NWORD; w++) begin : g_word
        for (genvar b = 0; b < 32; b++) begin : g_bit
            localparam int SRC = w * 32 + b;
            if (SRC == 0) begin : g_reserved
                // R7: source 0 is never a candidate
                assign elig[0] = 1'b0;
            end else if (SRC < NUM_SRC) begin : g_live
                // R1: pending, not in service, enabled
                assign elig[SRC] = pend_words[SRC] & ~claim_words[SRC] & en_words[SRC];
            end
        end
    end

    // Bits with no source behind them are deliberately left unread
    logic unused_src0;
    assign unused_src0 = pend_words[0] ^ claim_words[0] ^ en_words[0];

    if (FLAT_W > NUM_SRC) begin : g_pad
        logic unused_pad;
        assign unused_pad = ^{pend_words[FLAT_W-1:NUM_SRC],
                              claim_words[FLAT_W-1:NUM_SRC],
                              en_words[FLAT_W-1:NUM_SRC]};
    end

endmodule

// File: rtl/irq_pick_node.sv
module irq_pick_node #(
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6
) (
    input  logic              lo_vld,
    input  logic [PRIO_W-1:0] lo_pr,
    input  logic [ID_W-1:0]   lo_id,
    input  logic              hi_vld,
    input  logic [PRIO_W-1:0] hi_pr,
    input  logic [ID_W-1:0]   hi_id,
    output logic              out_vld,
    output logic [PRIO_W-1:0] out_pr,
    output logic [ID_W-1:0]   out_id
);

    // The "lo" side always covers lower source numbers than the "hi" side.
    // The hi side wins only on a strictly greater priority (R3).
    logic take_hi;

    always_comb begin
        take_hi = hi_vld && (!lo_vld || (hi_pr > lo_pr));
        if (take_hi) begin
            out_vld = 1'b1;
            out_pr  = hi_pr;
            out_id  = hi_id;
        end else begin
            out_vld = lo_vld;
            out_pr  = lo_pr;
            out_id  = lo_id;
        end
    end

endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree #(
    parameter int NUM_SRC = 40,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = irq_pick_pkg::id_width(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        elig,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         thresh,
    output logic                      best_vld,
    output logic [ID_W-1:0]           best_id
);

    localparam int LEAVES = irq_pick_pkg::leaf_count(NUM_SRC);
    localparam int NODES  = 2 * LEAVES - 1;
    localparam int FIRST_LEAF = LEAVES - 1;

    // Heap layout: node i has children 2i+1 (lower IDs) and 2i+2
    logic              nd_vld [NODES];
    logic [PRIO_W-1:0] nd_pr  [NODES];
    logic [ID_W-1:0]   nd_id  [NODES];

    // Leaves: a candidate enters the tree only above the threshold (R2)
    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < NUM_SRC) begin : g_real
            assign nd_vld[FIRST_LEAF+k] = elig[k] && (prio_flat[k*PRIO_W +: PRIO_W] > thresh);
            assign nd_pr[FIRST_LEAF+k]  = prio_flat[k*PRIO_W +: PRIO_W];
            assign nd_id[FIRST_LEAF+k]  = ID_W'(k);
        end else begin : g_empty
            assign nd_vld[FIRST_LEAF+k] = 1'b0;
            assign nd_pr[FIRST_LEAF+k]  = '0;
            assign nd_id[FIRST_LEAF+k]  = '0;
        end
    end

    // Internal comparison nodes
    for (genvar i = 0; i < FIRST_LEAF; i++) begin : g_node
        irq_pick_node #(
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
        ) u_node (
            .lo_vld  (nd_vld[2*i+1]),
            .lo_pr   (nd_pr[2*i+1]),
            .lo_id   (nd_id[2*i+1]),
            .hi_vld  (nd_vld[2*i+2]),
            .hi_pr   (nd_pr[2*i+2]),
            .hi_id   (nd_id[2*i+2]),
            .out_vld (nd_vld[i]),
            .out_pr  (nd_pr[i]),
            .out_id  (nd_id[i])
        );
    end

    // R4: no surviving candidate means ID 0
    assign best_vld = nd_vld[0];
    assign best_id  = nd_vld[0] ? nd_id[0] : '0;

    logic unused_root_pr;
    assign unused_root_pr = ^nd_pr[0];

endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top #(
    parameter int NUM_SRC = 40,
    parameter int PRIO_W  = 3,
    parameter int NWORD   = irq_pick_pkg::word_count(NUM_SRC),
    parameter int ID_W    = irq_pick_pkg::id_width(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NWORD*32-1:0]       pend_words,
    input  logic [NWORD*32-1:0]       claim_words,
    input  logic [NWORD*32-1:0]       en_words,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         thresh,
    output logic [ID_W-1:0]           win_id,
    output logic                      irq_req
);

    logic [NUM_SRC-1:0] elig;
    logic               best_vld;
    logic [ID_W-1:0]    best_id;

    irq_pick_elig #(
        .NUM_SRC (NUM_SRC),
        .NWORD   (NWORD)
    ) u_elig (
        .pend_words  (pend_words),
        .claim_words (claim_words),
        .en_words    (en_words),
        .elig        (elig)
    );

    irq_pick_tree #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_tree (
        .elig      (elig),
        .prio_flat (prio_flat),
        .thresh    (thresh),
        .best_vld  (best_vld),
        .best_id   (best_id)
    );

    // R8: one register stage; R9: asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_id  <= '0;
            irq_req <= 1'b0;
        end else begin
            win_id  <= best_id;
            irq_req <= best_vld;
        end
    end

endmodule

// File: rtl/irq_pick_chk.sv
module irq_pick_chk #(
    parameter int NUM_SRC = 40,
    parameter int PRIO_W  = 3,
    parameter int NWORD   = irq_pick_pkg::word_count(NUM_SRC),
    parameter int ID_W    = irq_pick_pkg::id_width(NUM_SRC)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NWORD*32-1:0]       pend_words,
    input logic [NWORD*32-1:0]       claim_words,
    input logic [NWORD*32-1:0]       en_words,
    input logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input logic [PRIO_W-1:0]         thresh,
    input logic [ID_W-1:0]           win_id,
    input logic                      irq_req
);

    // Copy of the inputs taken at the same edge as the output register
    logic                      seen;
    logic [NWORD*32-1:0]       cp_pend;
    logic [NWORD*32-1:0]       cp_claim;
    logic [NWORD*32-1:0]       cp_en;
    logic [NUM_SRC*PRIO_W-1:0] cp_prio;
    logic [PRIO_W-1:0]         cp_thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            cp_pend  <= '0;
            cp_claim <= '0;
            cp_en    <= '0;
            cp_prio  <= '0;
            cp_thr   <= '0;
        end else begin
            seen     <= 1'b1;
            cp_pend  <= pend_words;
            cp_claim <= claim_words;
            cp_en    <= en_words;
            cp_prio  <= prio_flat;
            cp_thr   <= thresh;
        end
    end

    logic             win_ok;
    logic [PRIO_W-1:0] win_pr;
    always_comb begin
        win_ok = cp_pend[win_id] && !cp_claim[win_id] && cp_en[win_id];
        win_pr = (int'(win_id) < NUM_SRC) ? cp_prio[int'(win_id)*PRIO_W +: PRIO_W] : '0;
    end

    // R1
    winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && irq_req) |-> win_ok);

    // R2
    winner_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && irq_req) |-> (win_pr > cp_thr));

    // R5
    irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (win_id != '0));

    // R6
    id_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(win_id) < NUM_SRC);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (win_id == '0 && !irq_req));

endmodule

bind irq_pick_top irq_pick_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .NWORD   (NWORD),
    .ID_W    (ID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_words  (pend_words),
    .claim_words (claim_words),
    .en_words    (en_words),
    .prio_flat   (prio_flat),
    .thresh      (thresh),
    .win_id      (win_id),
    .irq_req     (irq_req)
);

// File: tb/irq_pick_top_tb.sv
module irq_pick_top_tb;

    localparam int NS  = 40;
    localparam int PW  = 3;
    localparam int NW  = 2;
    localparam int IW  = 6;
    localparam int FW  = NW * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [FW-1:0]   pend_words = '0;
    logic [FW-1:0]   claim_words = '0;
    logic [FW-1:0]   en_words = '0;
    logic [NS*PW-1:0] prio_flat = '0;
    logic [PW-1:0]   thresh = '0;
    logic [IW-1:0]   win_id;
    logic            irq_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_pick_top #(.NUM_SRC(NS), .PRIO_W(PW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_words  (pend_words),
        .claim_words (claim_words),
        .en_words    (en_words),
        .prio_flat   (prio_flat),
        .thresh      (thresh),
        .win_id      (win_id),
        .irq_req     (irq_req)
    );

    typedef struct packed {
        logic [63:0] pend;
        logic [63:0] claim;
        logic [63:0] en;
        logic [2:0]  base_pr;
        logic [5:0]  hot_id;
        logic [2:0]  hot_pr;
        logic [2:0]  thr;
        logic [5:0]  exp_id;
    } vec_t;

    localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

    localparam vec_t TABLE [12] = '{
        // R3: one source above the rest
        '{ALL, 64'h0, ALL, 3'd0, 6'd5, 3'd3, 3'd0, 6'd5},
        // R3: all equal, lowest nonzero ID
        '{ALL, 64'h0, ALL, 3'd2, 6'd5, 3'd2, 3'd1, 6'd1},
        // R2/R4: equal to threshold never wins
        '{ALL, 64'h0, ALL, 3'd2, 6'd5, 3'd2, 3'd2, 6'd0},
        // R7: only source 0 pending
        '{64'h1, 64'h0, ALL, 3'd7, 6'd0, 3'd7, 3'd0, 6'd0},
        // R1: all but 39 in service
        '{ALL, 64'h0000_007F_FFFF_FFFF, ALL, 3'd4, 6'd39, 3'd1, 3'd0, 6'd39},
        // R1/R6: only 20 and 33 enabled
        '{ALL, 64'h0, 64'h0000_0002_0010_0000, 3'd3, 6'd33, 3'd6, 3'd5, 6'd33},
        // R2: only the hot source clears a high threshold
        '{ALL, 64'h0, ALL, 3'd1, 6'd12, 3'd7, 3'd6, 6'd12},
        // R6: pad bit 45 ignored
        '{64'h0000_2000_0000_0008, 64'h0, ALL, 3'd5, 6'd0, 3'd0, 3'd0, 6'd3},
        // R1/R4: nothing enabled
        '{ALL, 64'h0, 64'h0, 3'd7, 6'd0, 3'd7, 3'd0, 6'd0},
        // R3: higher priority at higher ID
        '{64'h280, 64'h0, ALL, 3'd6, 6'd9, 3'd7, 3'd6, 6'd9},
        // R3: tie across words keeps ID 2
        '{64'h0000_0008_0000_0004, 64'h0, ALL, 3'd4, 6'd1, 3'd4, 3'd3, 6'd2},
        // R3: second word wins on priority
        '{64'h0000_0008_0000_0004, 64'h0, ALL, 3'd4, 6'd35, 3'd5, 3'd3, 6'd35}
    };

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_pick(input logic [FW-1:0] p, input logic [FW-1:0] c,
                                    input logic [FW-1:0] e, input logic [NS*PW-1:0] pr,
                                    input logic [PW-1:0] t);
        int best_pr = int'(t);
        int best = 0;
        for (int n = 1; n < NS; n++) begin
            if (p[n] && !c[n] && e[n] && int'(pr[n*PW +: PW]) > best_pr) begin
                best_pr = int'(pr[n*PW +: PW]);
                best = n;
            end
        end
        return best;
    endfunction

    task automatic drive_vec(input vec_t v);
        pend_words  = v.pend;
        claim_words = v.claim;
        en_words    = v.en;
        thresh      = v.thr;
        for (int n = 0; n < NS; n++)
            prio_flat[n*PW +: PW] = (n == int'(v.hot_id)) ? v.hot_pr : v.base_pr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset holds outputs low even with a winner present
        drive_vec(TABLE[0]);
        repeat (3) @(negedge clk);
        check_eq("R9 reset win_id", int'(win_id), 0);
        check_eq("R9 reset irq_req", int'(irq_req), 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            drive_vec(TABLE[i]);
            @(negedge clk);
            check_eq($sformatf("R3 table %0d win_id", i), int'(win_id), int'(TABLE[i].exp_id));
            check_eq($sformatf("R5 table %0d irq_req", i), int'(irq_req),
                     (TABLE[i].exp_id != 0) ? 1 : 0);
        end

        // R8: new inputs show up only after the next rising edge
        @(negedge clk);
        drive_vec(TABLE[0]);
        @(negedge clk);
        drive_vec(TABLE[6]);
        #1;
        check_eq("R8 hold before edge", int'(win_id), 5);
        @(negedge clk);
        check_eq("R8 update after edge", int'(win_id), 12);

        // R4: all pending but all in service
        pend_words = ALL; claim_words = ALL; en_words = ALL; thresh = '0;
        @(negedge clk);
        check_eq("R4 all in service", int'(win_id), 0);
        check_eq("R5 no request", int'(irq_req), 0);

        // R7: source 0 top priority does not mask source 1
        claim_words = '0; pend_words = 64'h3;
        prio_flat = '0;
        prio_flat[0 +: PW] = 3'd7;
        prio_flat[PW +: PW] = 3'd1;
        @(negedge clk);
        check_eq("R7 reserved source skipped", int'(win_id), 1);

        // Random comparison against the reference scan
        for (int r = 0; r < 400; r++) begin
            @(negedge clk);
            pend_words  = {$urandom(), $urandom()};
            claim_words = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            en_words    = {$urandom(), $urandom()};
            for (int n = 0; n < NS; n++) prio_flat[n*PW +: PW] = PW'($urandom());
            thresh = PW'($urandom() % 6);
            @(negedge clk);
            check_eq("R3 random win_id", int'(win_id),
                     ref_pick(pend_words, claim_words, en_words, prio_flat, thresh));
            check_eq("R5 random irq_req", int'(irq_req),
                     (ref_pick(pend_words, claim_words, en_words, prio_flat, thresh) != 0) ? 1 : 0);
        end

        // R9: asynchronous clear in mid-run
        @(negedge clk);
        drive_vec(TABLE[6]);
        @(negedge clk);
        check_eq("R9 before reset", int'(win_id), 12);
        rst_n = 1'b0;
        #1;
        check_eq("R9 async clear win_id", int'(win_id), 0);
        check_eq("R9 async clear irq_req", int'(irq_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R9 after release", int'(win_id), 12);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule